// File: doc/BRIEF.md
# System Interrupt Level Controller

This block collects 32 level-sensitive device interrupt lines into one system pending register. It masks them with a per-source disable register and finds the highest processor interrupt level among the sources that remain. It then raises a request, carrying that level, towards one CPU chosen by software. A synthesis-time table gives each source bit a 4-bit level, and several sources may share a level. Bit 31 of the disable register is a global gate that stops all delivery while it is set.

Software reaches the block through a small word-addressed register port. It can read the pending and disable registers and select the target CPU. Writing ones to the enable word clears disable bits. Writing ones to the disable word sets disable bits and drops the matching pending bits as well. Each CPU sees a request line and a level bus, and answers with a one-cycle acknowledge pulse. A request stays up, with a constant level, until that pulse arrives.

Top module: `sysirq_master`

## Requirements
- R1: A rising edge on `src_irq[i]` sets pending bit i at the clock edge that first samples it high. A falling edge clears the bit at the edge that first samples it low. A line that stays high does not set the bit again.
- R2: The word index is `addr[4:2]`. A read of word 0 returns the pending register with bit 31 forced to zero. A read of word 1 returns the disable register. Read data and `rvalid` appear one cycle after `rd_en`.
- R3: Writing word 2 clears in the disable register every bit that is one in `wdata`. This enables those sources.
- R4: Writing word 3 sets in the disable register every bit that is one in `wdata`, and clears the same bits in the pending register. The clear wins over a rising edge in the same cycle.
- R5: Writing word 4 stores `wdata` modulo `NUM_CPU` as the target CPU, where `NUM_CPU` is a power of two. A read of word 4 returns the stored value.
- R6: The effective set is pending AND NOT disable. A request is issued only when that set is nonzero and disable bit 31 is clear. Its level is the largest table level in the set. The default table maps bit i to level (i mod 15) + 1.
- R7: A new request is issued, one clock after the condition holds, only to the target CPU, and only when that CPU has no request outstanding. An outstanding request keeps its level until it is acknowledged.
- R8: The request drops one clock after the CPU's acknowledge is sampled while the request is high. Arbitration for that CPU runs again on the following clock.
- R9: After reset, pending is 0, disable is 0x004DFF80, target is 0, and no request is raised.
- R10: Reads of words 2, 3, 5, 6 and 7 return zero. Writes to words 0, 1, 5, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | 32 | Device interrupt lines |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte address; bits [4:2] select the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| cpu_ack | input | NUM_CPU | Per-CPU acknowledge pulse |
| cpu_req | output | NUM_CPU | Per-CPU interrupt request |
| cpu_lvl | output | 4*NUM_CPU | Per-CPU level, 4 bits per CPU, CPU c at [4c+3:4c] |

## Verification
The bench builds the block with its defaults: four CPUs and the table (i mod 15) + 1. With four CPUs, target writes of values 4 and above wrap, and requests can be steered to several CPUs while others still hold theirs. The table puts pairs of bits on the same level, such as 0 and 15, or 14 and 29, and gives bit 31 a real level. This makes shared levels, the level-15 maximum and the interplay of bit 31 as both a source and a gate all reachable.

// File: rtl/sysirq_pkg.sv
package sysirq_pkg;

    localparam int SRC_N    = 32;
    localparam int LVL_W    = 4;
    localparam int GATE_BIT = 31;
    localparam int WORD_W   = 3;

    localparam logic [WORD_W-1:0] WORD_PEND = 3'd0;
    localparam logic [WORD_W-1:0] WORD_MASK = 3'd1;
    localparam logic [WORD_W-1:0] WORD_ENA  = 3'd2;
    localparam logic [WORD_W-1:0] WORD_DIS  = 3'd3;
    localparam logic [WORD_W-1:0] WORD_TGT  = 3'd4;

    localparam logic [SRC_N-1:0] RESET_DISABLE = ~32'hFFB2_007F;

    typedef struct packed {
        logic             fire;
        logic [LVL_W-1:0] lvl;
    } irq_req_t;

    function automatic logic [SRC_N*LVL_W-1:0] default_level_map();
        logic [SRC_N*LVL_W-1:0] m;
        m = '0;
        for (int i = 0; i < SRC_N; i++) begin
            m[i*LVL_W +: LVL_W] = LVL_W'((i % 15) + 1);
        end
        return m;
    endfunction

endpackage

// File: rtl/sysirq_regs.sv
module sysirq_regs
    import sysirq_pkg::*;
#(
    parameter int TGT_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SRC_N-1:0]    src_irq,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   word,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    output logic                rvalid,
    output logic [SRC_N-1:0]    pend,
    output logic [SRC_N-1:0]    dis,
    output logic [TGT_W-1:0]    tgt
);

    logic [SRC_N-1:0] src_q;
    logic [SRC_N-1:0] rise, fall;
    logic [SRC_N-1:0] pend_n, dis_n;
    logic [TGT_W-1:0] tgt_n;
    logic [31:0]      rd_word;

    always_comb begin
        rise   = src_irq & ~src_q;
        fall   = ~src_irq & src_q;
        pend_n = (pend | rise) & ~fall;
        dis_n  = dis;
        tgt_n  = tgt;
        if (wr_en) begin
            case (word)
                WORD_ENA: dis_n = dis & ~wdata;
                WORD_DIS: begin
                    dis_n  = dis | wdata;
                    pend_n = pend_n & ~wdata;
                end
                WORD_TGT: tgt_n = wdata[TGT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (word)
            WORD_PEND: rd_word = pend & ~(32'd1 << GATE_BIT);
            WORD_MASK: rd_word = dis;
            WORD_TGT:  rd_word = 32'(tgt);
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            pend   <= '0;
            dis    <= RESET_DISABLE;
            tgt    <= '0;
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            src_q  <= src_irq;
            pend   <= pend_n;
            dis    <= dis_n;
            tgt    <= tgt_n;
            rvalid <= rd_en;
            rdata  <= rd_en ? rd_word : '0;
        end
    end

endmodule

// File: rtl/sysirq_resolve.sv
module sysirq_resolve
    import sysirq_pkg::*;
#(
    parameter logic [SRC_N*LVL_W-1:0] LEVEL_MAP = default_level_map()
) (
    input  logic [SRC_N-1:0] pend,
    input  logic [SRC_N-1:0] dis,
    output irq_req_t         req
);

    logic [SRC_N-1:0] eff;
    logic [LVL_W-1:0] best;

    always_comb begin
        eff  = pend & ~dis;
        best = '0;
        for (int i = 0; i < SRC_N; i++) begin
            if (eff[i] && (LEVEL_MAP[i*LVL_W +: LVL_W] > best)) begin
                best = LEVEL_MAP[i*LVL_W +: LVL_W];
            end
        end
        req.fire = (|eff) && !dis[GATE_BIT];
        req.lvl  = best;
    end

endmodule

// File: rtl/sysirq_deliver.sv
module sysirq_deliver
    import sysirq_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int TGT_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  irq_req_t                 req,
    input  logic [TGT_W-1:0]         tgt,
    input  logic [NUM_CPU-1:0]       cpu_ack,
    output logic [NUM_CPU-1:0]       cpu_req,
    output logic [NUM_CPU*LVL_W-1:0] cpu_lvl
);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic             busy;
        logic [LVL_W-1:0] lvl_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                busy  <= 1'b0;
                lvl_q <= '0;
            end else if (busy) begin
                if (cpu_ack[c]) busy <= 1'b0;
            end else if (req.fire && (tgt == TGT_W'(c))) begin
                busy  <= 1'b1;
                lvl_q <= req.lvl;
            end
        end

        assign cpu_req[c]                 = busy;
        assign cpu_lvl[c*LVL_W +: LVL_W]  = lvl_q;
    end

endmodule

// File: rtl/sysirq_master.sv
module sysirq_master
    import sysirq_pkg::*;
#(
    parameter int                     NUM_CPU   = 4,
    parameter logic [SRC_N*LVL_W-1:0] LEVEL_MAP = default_level_map()
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [31:0]              src_irq,
    input  logic                     rd_en,
    input  logic                     wr_en,
    input  logic [4:0]               addr,
    input  logic [31:0]              wdata,
    output logic [31:0]              rdata,
    output logic                     rvalid,
    input  logic [NUM_CPU-1:0]       cpu_ack,
    output logic [NUM_CPU-1:0]       cpu_req,
    output logic [NUM_CPU*4-1:0]     cpu_lvl
);

    localparam int TGT_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

    logic [SRC_N-1:0] pend_bits;
    logic [SRC_N-1:0] dis_bits;
    logic [TGT_W-1:0] tgt_cpu;
    irq_req_t         arb;
    logic             unused_addr_lsb;

    assign unused_addr_lsb = ^addr[1:0];

    sysirq_regs #(.TGT_W(TGT_W)) i_regs (
        .clk    (clk),
        .rst    (rst),
        .src_irq(src_irq),
        .rd_en  (rd_en),
        .wr_en  (wr_en),
        .word   (addr[4:2]),
        .wdata  (wdata),
        .rdata  (rdata),
        .rvalid (rvalid),
        .pend   (pend_bits),
        .dis    (dis_bits),
        .tgt    (tgt_cpu)
    );

    sysirq_resolve #(.LEVEL_MAP(LEVEL_MAP)) i_resolve (
        .pend(pend_bits),
        .dis (dis_bits),
        .req (arb)
    );

    sysirq_deliver #(.NUM_CPU(NUM_CPU), .TGT_W(TGT_W)) i_deliver (
        .clk    (clk),
        .rst    (rst),
        .req    (arb),
        .tgt    (tgt_cpu),
        .cpu_ack(cpu_ack),
        .cpu_req(cpu_req),
        .cpu_lvl(cpu_lvl)
    );

endmodule

// File: rtl/sysirq_chk.sv
module sysirq_chk #(
    parameter int NUM_CPU = 4,
    parameter int TGT_W   = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 rd_en,
    input logic                 wr_en,
    input logic [4:0]           addr,
    input logic [31:0]          wdata,
    input logic [31:0]          rdata,
    input logic                 rvalid,
    input logic [NUM_CPU-1:0]   cpu_ack,
    input logic [NUM_CPU-1:0]   cpu_req,
    input logic [NUM_CPU*4-1:0] cpu_lvl,
    input logic [31:0]          pend,
    input logic [TGT_W-1:0]     tgt
);

    // R2
    rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rvalid);

    // R2
    pend_read_b31_chk: assert property (@(posedge clk) disable iff (rst)
        (rvalid && $past(rd_en && (addr[4:2] == 3'd0))) |-> !rdata[31]);

    // R4
    dis_drops_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr[4:2] == 3'd3)) |=> ((pend & $past(wdata)) == 32'd0));

    // R7
    one_new_req_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cpu_req & ~$past(cpu_req)));

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
        // R7
        req_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (cpu_req[c] && !cpu_ack[c]) |=> (cpu_req[c] && $stable(cpu_lvl[c*4 +: 4])));

        // R7
        req_to_target_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(cpu_req[c]) |-> ($past(tgt) == TGT_W'(c)));

        // R8
        ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
            (cpu_req[c] && cpu_ack[c]) |=> !cpu_req[c]);
    end

endmodule

bind sysirq_master sysirq_chk #(.NUM_CPU(NUM_CPU), .TGT_W(TGT_W)) i_chk (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .rvalid (rvalid),
    .cpu_ack(cpu_ack),
    .cpu_req(cpu_req),
    .cpu_lvl(cpu_lvl),
    .pend   (pend_bits),
    .tgt    (tgt_cpu)
);

// File: tb/test_sysirq_master.sv
`timescale 1ns/1ps
module test_sysirq_master;

    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [31:0]   src_irq = '0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [4:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          rvalid;
    logic [NC-1:0] cpu_ack = '0;
    logic [NC-1:0] cpu_req;
    logic [NC*4-1:0] cpu_lvl;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model state
    logic [31:0] m_srcq, m_pend, m_dis, m_rdata;
    logic [1:0]  m_tgt;
    logic        m_rvalid;
    logic [NC-1:0] m_busy;
    logic [3:0]  m_lvl [NC];

    always #2.5 clk = ~clk;

    sysirq_master #(.NUM_CPU(NC)) i_sysirq_master (
        .clk(clk), .rst(rst), .src_irq(src_irq), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .cpu_ack(cpu_ack), .cpu_req(cpu_req), .cpu_lvl(cpu_lvl)
    );

    function automatic logic [3:0] lvl_of(int i);
        return 4'((i % 15) + 1);
    endfunction

    function automatic logic [31:0] read_of(logic [2:0] w);
        case (w)
            3'd0: return m_pend & 32'h7FFF_FFFF;
            3'd1: return m_dis;
            3'd4: return 32'(m_tgt);
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_srcq = '0; m_pend = '0; m_dis = 32'h004D_FF80; m_tgt = '0;
        m_rvalid = 0; m_rdata = '0; m_busy = '0;
        for (int c = 0; c < NC; c++) m_lvl[c] = '0;
    endtask

    task automatic model_edge();
        logic [31:0] rise, fall, eff, np, nd;
        logic [3:0] best;
        logic fire;
        logic [2:0] w;
        w = addr[4:2];
        rise = src_irq & ~m_srcq;
        fall = ~src_irq & m_srcq;
        eff = m_pend & ~m_dis;
        best = 0;
        for (int i = 0; i < 32; i++) if (eff[i] && lvl_of(i) > best) best = lvl_of(i);
        fire = (eff != 0) && !m_dis[31];
        for (int c = 0; c < NC; c++) begin
            if (m_busy[c]) begin
                if (cpu_ack[c]) m_busy[c] = 0;
            end else if (fire && m_tgt == 2'(c)) begin
                m_busy[c] = 1; m_lvl[c] = best;
            end
        end
        m_rvalid = rd_en;
        m_rdata = rd_en ? read_of(w) : 32'd0;
        np = (m_pend | rise) & ~fall;
        nd = m_dis;
        if (wr_en && w == 3'd2) nd = m_dis & ~wdata;
        if (wr_en && w == 3'd3) begin nd = m_dis | wdata; np = np & ~wdata; end
        if (wr_en && w == 3'd4) m_tgt = wdata[1:0];
        m_pend = np; m_dis = nd; m_srcq = src_irq;
    endtask

    task automatic compare_all();
        check("R6/R7 req", 32'(cpu_req), 32'(m_busy));
        for (int c = 0; c < NC; c++)
            if (m_busy[c]) check("R6 lvl", 32'(cpu_lvl[c*4 +: 4]), 32'(m_lvl[c]));
        check("R2 rvalid", 32'(rvalid), 32'(m_rvalid));
        if (m_rvalid) check("R2/R5 rdata", rdata, m_rdata);
    endtask

    task automatic step();
        @(posedge clk);
        if (!rst) model_edge(); else model_reset();
        @(negedge clk);
        if (!rst) compare_all();
        rd_en = 0; wr_en = 0; cpu_ack = '0;
    endtask

    task automatic wr(logic [2:0] w, logic [31:0] d);
        wr_en = 1; addr = {w, 2'b00}; wdata = d; step();
    endtask

    task automatic rd(logic [2:0] w, logic [31:0] exp, string tag);
        rd_en = 1; addr = {w, 2'b00}; step();
        check(tag, rdata, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) step();
        rst = 0;
        step();
        check("R9 no request after reset", 32'(cpu_req), 32'd0);
        rd(3'd0, 32'd0, "R9 pending reset");
        rd(3'd1, 32'h004D_FF80, "R9 disable reset");
        rd(3'd4, 32'd0, "R9 target reset");

        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd1, 32'd0, "R3 enable all");

        // shared level: bits 0 and 15 at level 1, bit 3 at level 4
        src_irq = 32'h0000_8009; step(); step();
        check("R6 request raised", 32'(cpu_req[0]), 32'd1);
        check("R6 max level", 32'(cpu_lvl[3:0]), 32'd4);
        rd(3'd0, 32'h0000_8009, "R1 pending set");

        src_irq[14] = 1'b1; step(); step();
        check("R7 level held", 32'(cpu_lvl[3:0]), 32'd4);
        cpu_ack[0] = 1'b1; step();
        check("R8 drop after ack", 32'(cpu_req[0]), 32'd0);
        step();
        check("R8 rearbitrated", 32'(cpu_req[0]), 32'd1);
        check("R8 new level", 32'(cpu_lvl[3:0]), 32'd15);

        // global gate through bit 31
        wr(3'd3, 32'h8000_0000);
        cpu_ack[0] = 1'b1; step(); step(); step();
        check("R6 gate bit31 blocks", 32'(cpu_req[0]), 32'd0);
        wr(3'd2, 32'h8000_0000); step();
        check("R6 gate reopened", 32'(cpu_req[0]), 32'd1);

        wr(3'd3, 32'h0000_4000);
        rd(3'd0, 32'h0000_8009, "R4 disable drops pending");
        src_irq = '0; step();
        rd(3'd0, 32'd0, "R1 falling clears");

        cpu_ack = '1; step();
        wr(3'd4, 32'd6);
        rd(3'd4, 32'd2, "R5 target wraps");
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, 32'd0, "R10 write word0 ignored");
        rd(3'd6, 32'd0, "R10 unmapped read");
        rd(3'd2, 32'd0, "R10 write-only reads zero");
        src_irq[5] = 1'b1; step(); step();
        check("R7 routed to target", 32'(cpu_req[2]), 32'd1);
        check("R7 routed level", 32'(cpu_lvl[11:8]), 32'd6);
        check("R7 other cpu idle", 32'(cpu_req[0]), 32'd0);

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            if (($urandom % 6) == 0) src_irq[$urandom % 32] = ~src_irq[$urandom % 32];
            r = $urandom % 10;
            if (r < 2) begin
                rd_en = 1; addr = {3'($urandom % 8), 2'($urandom % 4)};
            end else if (r < 4) begin
                int w;
                w = $urandom % 8;
                wr_en = 1; addr = {3'(w), 2'b00};
                wdata = (w == 3) ? (32'd1 << ($urandom % 32)) : $urandom;
            end
            for (int c = 0; c < NC; c++) cpu_ack[c] = (($urandom % 4) == 0);
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule